// File: doc/BRIEF.md
# Timer Output Gating and Reset Strap Latch

This block sits between an external interval timer and two output pins. The first timer output reaches the speaker pin only when an enable bit in a control port is set. Software writes that port through the I/O bus. The second timer output drives a CPU slowdown pin, which is used to throttle the processor by pulse-width modulation. The slowdown pin stays quiet after reset. It starts to follow the timer only after software has read an address inside a small I/O window, and from then on it keeps following until the next reset.

The slowdown pin is shared. While reset is held, the pin is an input that carries a configuration strap. The level seen at the last clock edge of reset is latched. A high level means the boot firmware lives on the local peripheral bus, and a low level means it lives on the expansion bus. One clock after reset is released, the block turns on the pin's output driver. The timer gating is combinational: a timer edge reaches its pin in the same cycle. The control port and the arm flag are registers. All I/O strobes and timer inputs are plain level signals with no handshake.

Top module: `tmr_gate_top`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `spk_out`, `slow_out` and `pad_oe` are all 0, whatever the timer inputs are.
- R2: `spk_out` equals `tmr_spk` ANDed with bit 1 of the speaker control port, in the same cycle with no register delay.
- R3: A clock edge with `io_wr` high and `io_addr` = 16'h0061 loads `io_wdata` into the speaker control port. Writes to any other address, and reads of any address, leave the port unchanged. The port resets to 0.
- R4: `slow_out` stays 0 until a clock edge with `io_rd` high and `io_addr` in 16'h0048..16'h004B. In the cycle where that read is presented, `slow_out` is still 0.
- R5: Once armed, `slow_out` equals `tmr_slow` in the same cycle, and it stays armed until reset. Reads of 16'h0047 or 16'h004C and writes inside the window do not arm it.
- R6: `strap_local` holds the value `pad_in` had at the last rising clock edge with `rst` high. A value of 1 selects firmware on the local bus and 0 selects the expansion bus.
- R7: While `rst` is low, `strap_local` does not change, whatever `pad_in` does.
- R8: `pad_oe` rises at the first clock edge with `rst` low and stays at 1 until reset.
- R9: Asserting reset again clears both the arm flag and the control port, and it captures a new strap value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tmr_spk | input | 1 | Timer output that feeds the speaker |
| tmr_slow | input | 1 | Timer output that feeds the slowdown pin |
| io_rd | input | 1 | I/O read strobe |
| io_wr | input | 1 | I/O write strobe |
| io_addr | input | 16 | I/O address |
| io_wdata | input | 8 | I/O write data |
| pad_in | input | 1 | Level sampled from the shared pin during reset |
| spk_out | output | 1 | Gated speaker drive |
| slow_out | output | 1 | Gated slowdown drive |
| strap_local | output | 1 | Latched strap: 1 = local bus firmware, 0 = expansion bus |
| pad_oe | output | 1 | Output enable of the shared pin |

## Verification
The bench reads the addresses just outside the arming window (16'h0047 and 16'h004C). A design with an off-by-one compare would start throttling early. It also writes inside the window, which an arm that decodes only the address would wrongly accept. The strap pin changes on the last reset cycle and again after release: a design that latches early shows the stale level, and one that keeps sampling lets the strap drift. Random traffic mixes writes to the control port and to its neighbours with toggling timers, so a port that ignores the address, or that gates on the wrong bit, produces a speaker mismatch. A second reset with the opposite strap then confirms that the arm flag does not survive reset.

// File: rtl/tmr_gate_pkg.sv
package tmr_gate_pkg;
  localparam int ADDR_W = 16;
  localparam int DATA_W = 8;
  localparam logic [ADDR_W-1:0] SPK_PORT_ADDR = 16'h0061;
  localparam int SPK_EN_BIT = 1;
  localparam logic [ADDR_W-1:0] ARM_WIN_BASE = 16'h0048;
  localparam int ARM_WIN_SPAN = 4;
endpackage

// File: rtl/tmr_spk_port.sv
module tmr_spk_port #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter logic [ADDR_W-1:0] PORT_ADDR = 16'h0061,
  parameter int EN_BIT = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              io_wr,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic [DATA_W-1:0] io_wdata,
  output logic              spk_en
);
  logic [DATA_W-1:0] port_q;
  logic              hit;

  assign hit = io_wr && (io_addr == PORT_ADDR);

  always_ff @(posedge clk) begin
    if (rst) port_q <= '0;
    else if (hit) port_q <= io_wdata;
  end

  assign spk_en = port_q[EN_BIT];

  // R3
  port_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !hit |=> $stable(port_q));
  // R3
  port_load_chk: assert property (@(posedge clk) disable iff (rst)
    hit |=> (port_q == $past(io_wdata)));
endmodule

// File: rtl/tmr_slow_arm.sv
module tmr_slow_arm #(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] WIN_BASE = 16'h0048,
  parameter int WIN_SPAN = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              io_rd,
  input  logic [ADDR_W-1:0] io_addr,
  output logic              armed
);
  localparam logic [ADDR_W-1:0] WIN_LAST = WIN_BASE + ADDR_W'(WIN_SPAN - 1);
  localparam bit POW2_ALIGNED = ((WIN_SPAN & (WIN_SPAN - 1)) == 0) &&
                                ((int'(WIN_BASE) % WIN_SPAN) == 0);

  logic in_win;
  logic armed_q;

  generate
    if (POW2_ALIGNED) begin : g_mask
      localparam logic [ADDR_W-1:0] WIN_MASK = ~ADDR_W'(WIN_SPAN - 1);
      assign in_win = ((io_addr & WIN_MASK) == WIN_BASE);
    end else begin : g_range
      assign in_win = (io_addr >= WIN_BASE) && (io_addr <= WIN_LAST);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) armed_q <= 1'b0;
    else if (io_rd && in_win) armed_q <= 1'b1;
  end

  assign armed = armed_q;

  // R5
  arm_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    armed_q |=> armed_q);
  // R4
  arm_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(armed_q) |-> $past(io_rd && (io_addr >= WIN_BASE) && (io_addr <= WIN_LAST)));
endmodule

// File: rtl/tmr_strap_latch.sv
module tmr_strap_latch (
  input  logic clk,
  input  logic rst,
  input  logic pad_in,
  output logic strap,
  output logic pad_oe
);
  logic strap_q;
  logic oe_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      strap_q <= pad_in;
      oe_q    <= 1'b0;
    end else begin
      oe_q    <= 1'b1;
    end
  end

  assign strap  = strap_q;
  assign pad_oe = oe_q;

  // R7
  strap_frozen_chk: assert property (@(posedge clk) disable iff (rst)
    oe_q |=> $stable(strap_q));
  // R8
  oe_rise_chk: assert property (@(posedge clk) disable iff (rst)
    !oe_q |=> oe_q);
  // R1
  oe_reset_chk: assert property (@(posedge clk)
    rst |=> !oe_q);
endmodule

// File: rtl/tmr_gate_top.sv
module tmr_gate_top
  import tmr_gate_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              tmr_spk,
  input  logic              tmr_slow,
  input  logic              io_rd,
  input  logic              io_wr,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic [DATA_W-1:0] io_wdata,
  input  logic              pad_in,
  output logic              spk_out,
  output logic              slow_out,
  output logic              strap_local,
  output logic              pad_oe
);
  logic spk_en;
  logic armed;

  tmr_spk_port #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .PORT_ADDR(SPK_PORT_ADDR), .EN_BIT(SPK_EN_BIT)
  ) u_port (
    .clk(clk), .rst(rst), .io_wr(io_wr), .io_addr(io_addr),
    .io_wdata(io_wdata), .spk_en(spk_en)
  );

  tmr_slow_arm #(
    .ADDR_W(ADDR_W), .WIN_BASE(ARM_WIN_BASE), .WIN_SPAN(ARM_WIN_SPAN)
  ) u_arm (
    .clk(clk), .rst(rst), .io_rd(io_rd), .io_addr(io_addr), .armed(armed)
  );

  tmr_strap_latch u_strap (
    .clk(clk), .rst(rst), .pad_in(pad_in),
    .strap(strap_local), .pad_oe(pad_oe)
  );

  assign spk_out  = tmr_spk & spk_en;
  assign slow_out = tmr_slow & armed;

  // R1
  spk_quiet_chk: assert property (@(posedge clk)
    rst |=> !spk_out);
  // R4
  slow_quiet_chk: assert property (@(posedge clk)
    rst |=> !slow_out);
endmodule

// File: tb/tmr_gate_top_test.sv
module tmr_gate_top_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tmr_spk = 1'b0, tmr_slow = 1'b0, io_rd = 1'b0, io_wr = 1'b0, pad_in = 1'b0;
  logic [15:0] io_addr = '0;
  logic [7:0]  io_wdata = '0;
  logic spk_out, slow_out, strap_local, pad_oe;

  int n_run = 0, n_fail = 0;
  logic [7:0] m_ctrl = '0;
  logic m_arm = 1'b0;
  bit done = 0;

  always #5 clk = ~clk;

  tmr_gate_top uut (
    .clk(clk), .rst(rst), .tmr_spk(tmr_spk), .tmr_slow(tmr_slow),
    .io_rd(io_rd), .io_wr(io_wr), .io_addr(io_addr), .io_wdata(io_wdata),
    .pad_in(pad_in), .spk_out(spk_out), .slow_out(slow_out),
    .strap_local(strap_local), .pad_oe(pad_oe)
  );

  function automatic logic f_win(logic [15:0] a);
    return (a >= 16'h0048) && (a <= 16'h004B);
  endfunction

  function automatic logic f_spk(logic t, logic [7:0] c);
    return t & c[1];
  endfunction

  task automatic chk(string req, logic act, logic exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step(logic rd, logic wr, logic [15:0] a, logic [7:0] d,
                      logic ts, logic tl);
    @(negedge clk);
    io_rd = rd; io_wr = wr; io_addr = a; io_wdata = d;
    tmr_spk = ts; tmr_slow = tl;
    #2;
    chk("R2 R3 speaker", spk_out, f_spk(ts, m_ctrl));
    chk(m_arm ? "R5 slowdown" : "R4 slowdown", slow_out, m_arm & tl);
    if (wr && a == 16'h0061) m_ctrl = d;
    if (rd && f_win(a)) m_arm = 1'b1;
    @(posedge clk);
  endtask

  task automatic do_reset(logic sv);
    @(negedge clk);
    rst = 1'b1; pad_in = ~sv; tmr_spk = 1'b1; tmr_slow = 1'b1;
    io_rd = 1'b0; io_wr = 1'b0;
    repeat (2) @(negedge clk);
    #2;
    chk("R1 oe in reset", pad_oe, 1'b0);
    chk("R1 spk in reset", spk_out, 1'b0);
    chk("R1 slow in reset", slow_out, 1'b0);
    pad_in = sv;
    @(negedge clk);
    rst = 1'b0; pad_in = ~sv;
    m_ctrl = '0; m_arm = 1'b0;
    #2;
    chk("R1 oe first cycle", pad_oe, 1'b0);
    chk("R1 R9 spk cleared", spk_out, 1'b0);
    chk("R1 R9 slow cleared", slow_out, 1'b0);
    @(negedge clk);
    #2;
    chk("R8 oe on", pad_oe, 1'b1);
    chk("R6 strap", strap_local, sv);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual running expected done");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4021));
    do_reset(1'b1);
    // R7: pad_in moves, strap holds
    for (int i = 0; i < 4; i++) begin
      @(negedge clk); pad_in = i[0]; #2;
      chk("R7 strap frozen", strap_local, 1'b1);
      chk("R8 oe held", pad_oe, 1'b1);
    end
    // R3: neighbour writes and reads of the port do not load it
    step(0, 1, 16'h0060, 8'hFF, 1, 0);
    step(0, 1, 16'h0062, 8'hFF, 1, 0);
    step(1, 0, 16'h0061, 8'hFF, 1, 0);
    step(0, 0, 16'h0000, 8'h00, 1, 0);
    // R3: the wrong bit set does not enable the speaker
    step(0, 1, 16'h0061, 8'hFD, 1, 0);
    step(0, 0, 16'h0000, 8'h00, 1, 0);
    step(0, 1, 16'h0061, 8'h02, 1, 0);
    step(0, 0, 16'h0000, 8'h00, 1, 0);
    step(0, 0, 16'h0000, 8'h00, 0, 0);
    // R5: reads just outside the window and writes inside it do not arm
    step(1, 0, 16'h0047, 8'h00, 0, 1);
    step(1, 0, 16'h004C, 8'h00, 0, 1);
    step(0, 1, 16'h0049, 8'h00, 0, 1);
    step(0, 0, 16'h0000, 8'h00, 0, 1);
    // R4: the arming read itself still sees slow_out low
    step(1, 0, 16'h004B, 8'h00, 0, 1);
    step(0, 0, 16'h0000, 8'h00, 0, 1);
    step(0, 0, 16'h0000, 8'h00, 0, 0);
    step(0, 0, 16'h0000, 8'h00, 0, 1);
    // R9: a new reset captures a new strap and disarms
    do_reset(1'b0);
    step(0, 0, 16'h0000, 8'h00, 1, 1);
    // random traffic
    for (int i = 0; i < 400; i++) begin
      logic [15:0] a;
      int sel;
      sel = int'($urandom_range(0, 9));
      case (sel)
        0: a = 16'h0061;
        1: a = 16'h0060;
        2: a = 16'h0047;
        3: a = 16'h004C;
        4: a = 16'h0048 + 16'($urandom_range(0, 3));
        5: a = 16'h0061;
        default: a = 16'($urandom);
      endcase
      step(($urandom_range(0, 7) == 0), ($urandom_range(0, 2) == 0), a,
           8'($urandom), 1'($urandom), 1'($urandom));
    end
    @(negedge clk); #2;
    chk("R7 strap after traffic", strap_local, 1'b0);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule